// File: doc/BRIEF.md
# Masked-Byte CRC16 Wake Pattern Filter

This block watches a stream of received frame bytes and decides, once per frame, whether the frame matches one programmable wake pattern. Software programs four things: a control word, a 16-bit expected check value, and a 128-bit byte mask made of eight 16-bit words. Starting at a programmed byte offset into the frame, a window of up to 128 bytes is examined. Only the bytes whose mask bit is set are folded into a CRC16. When the last byte of the frame arrives, the block bit-reverses the CRC and compares it with the expected value. If they are equal, it raises a single-cycle match pulse.

The match can also be made conditional on the class of the destination address. One control bit requires a multicast destination. Another requires the all-ones broadcast destination. For example, an ARP wake uses offset 12, the broadcast requirement, and a mask that selects the two type bytes 0x08, 0x06. A "wake on any multicast" setting uses an empty mask and the multicast requirement. Frame reception, the wake status register and the power-event pin are handled elsewhere.

The configuration inputs must be held stable while a frame is in flight.

Top module: `wake_pattern_filter`

## Requirements
- R1: After reset, and while no frame ends, `match_pulse` stays low.
- R2: When control bit 15 (enable) is clear, no frame produces a match.
- R3: The byte offset is taken from control bits [7:0]. The frame byte at position offset+i (the first byte of a frame is position 0, 0 <= i < 128) enters the CRC exactly when `cfg_mask[i]` is set; mask word k occupies `cfg_mask[16k+15:16k]`, bit j of it selecting window byte 16k+j. Unselected bytes have no effect on the result.
- R4: The CRC register starts at 0xFFFF for every frame. It folds each selected byte least significant bit first, using the reflected 0x8005 polynomial (shift-right constant 0xA001). Its final 16-bit value, bit-reversed, must equal `cfg_crc`; on any mismatch there is no match.
- R5: A match is signalled by `match_pulse` high for exactly the one cycle following the clock edge that accepts the end-of-frame byte. Back-to-back frames may give pulses on consecutive cycles.
- R6: When control bit 9 is set, a frame matches only if bit 0 of its first byte is 1 (multicast destination).
- R7: When control bit 8 is set, a frame matches only if it has at least six bytes and its first six bytes are all 0xFF (broadcast destination).
- R8: A frame that ends before the position of its last selected byte never matches.
- R9: With all mask bits zero, the compared value is 0xFFFF. Every frame that meets the address requirements therefore matches when `cfg_crc` is 0xFFFF.
- R10: Cycles with `in_valid` low are ignored, including their data, start and end strobes. A byte accepted with `in_sof` set restarts frame tracking at position 0.
- R11: With offset 12, the broadcast requirement and mask 0x0003, a broadcast frame whose bytes 12 and 13 are 0x08, 0x06 matches when `cfg_crc` holds the reversed CRC of those two bytes. The same frame sent to a unicast destination does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | This byte is the first of a frame (qualified by in_valid) |
| in_eof | input | 1 | This byte is the last of a frame (qualified by in_valid) |
| cfg_ctrl | input | 16 | Bit 15 enable, bit 9 multicast required, bit 8 broadcast required, bits 7:0 byte offset |
| cfg_crc | input | 16 | Expected bit-reversed CRC16 of the selected bytes |
| cfg_mask | input | 128 | Byte-select mask, eight 16-bit words, bit i selects window byte i |
| match_pulse | output | 1 | One-cycle pulse after a matching frame's last byte |

## Verification
The filter's internal state is only visible at the end of a frame. A corrupted CRC register, a slipped position counter or a stale selected-byte count therefore shows up one cycle after the end-of-frame byte, as a missing or extra pulse. Depending on where the corruption happened, that can be up to a whole frame length later. The address-class flags follow the same rule, but they only matter when their control bit is set. For this reason, frames are sent both with each qualifier set and with it clear. The mask cases place selected bytes at the first and last window positions, and they corrupt selected and unselected bytes separately. A window misplaced by one byte then turns into a visible pulse difference, rather than an error that cancels out.

// File: rtl/wpf_pkg.sv
package wpf_pkg;

  // control word field positions, decoded by the filter
  localparam int CTL_EN_BIT = 15;
  localparam int CTL_MC_BIT = 9;
  localparam int CTL_BC_BIT = 8;
  localparam int OFS_W      = 8;

  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'hA001;

  // fold one byte, lsb first, into a reflected crc16 register
  function automatic logic [15:0] crc16_fold(input logic [15:0] crc,
                                             input logic [7:0]  b);
    logic [15:0] c;
    c = crc ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15 - i];
    return r;
  endfunction

endpackage

// File: rtl/wpf_frame_pos.sv
module wpf_frame_pos #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  output logic [POS_W-1:0] cur_pos
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q;

  assign cur_pos = sof ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    pos_q <= '0;
    else if (beat) pos_q <= (cur_pos == POS_MAX) ? cur_pos : cur_pos + 1'b1;
  end

  // R10: a start byte puts the next byte at position 1
  p_pos_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof) |=> (pos_q == POS_W'(1)))
    else $error("p_pos_restart_r10");

  // R10: idle cycles leave the position untouched
  p_pos_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(pos_q))
    else $error("p_pos_hold_r10");
endmodule

// File: rtl/wpf_byte_select.sv
module wpf_byte_select #(
  parameter int WIN_BYTES = 128,
  parameter int POS_W     = 9,
  parameter int OFS_W     = 8
) (
  input  logic [POS_W-1:0]     cur_pos,
  input  logic [OFS_W-1:0]     ofs,
  input  logic [WIN_BYTES-1:0] mask,
  output logic                 in_win,
  output logic                 sel
);
  localparam int IDX_W = $clog2(WIN_BYTES);

  logic [POS_W-1:0] rel;

  assign rel    = cur_pos - POS_W'(ofs);
  assign in_win = (cur_pos >= POS_W'(ofs)) && (rel[POS_W-1:IDX_W] == '0);
  assign sel    = in_win && mask[rel[IDX_W-1:0]];
endmodule

// File: rtl/wpf_crc_acc.sv
module wpf_crc_acc
  import wpf_pkg::*;
#(
  parameter int WIN_BYTES = 128,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             sel,
  input  logic [7:0]       data,
  output logic [15:0]      crc_now,
  output logic [CNT_W-1:0] taken_now
);
  logic [15:0]      crc_q;
  logic [CNT_W-1:0] taken_q;
  logic [15:0]      crc_base;
  logic [CNT_W-1:0] taken_base;

  assign crc_base   = sof ? CRC_SEED : crc_q;
  assign taken_base = sof ? '0 : taken_q;
  assign crc_now    = sel ? crc16_fold(crc_base, data) : crc_base;
  assign taken_now  = sel ? taken_base + 1'b1 : taken_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q   <= CRC_SEED;
      taken_q <= '0;
    end else if (beat) begin
      crc_q   <= crc_now;
      taken_q <= taken_now;
    end
  end

  // R4: a frame whose first byte is unselected restarts from the seed
  p_seed_on_sof_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof && !sel) |=> (crc_q == CRC_SEED))
    else $error("p_seed_on_sof_r4");

  // R8: the window never yields more selected bytes than it holds
  p_taken_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q <= CNT_W'(WIN_BYTES))
    else $error("p_taken_limit_r8");
endmodule

// File: rtl/wpf_addr_qual.sv
module wpf_addr_qual #(
  parameter int POS_W      = 9,
  parameter int ADDR_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic [POS_W-1:0] cur_pos,
  input  logic [7:0]       data,
  output logic             bcast_now,
  output logic             mcast_now
);
  logic run_q, mc_q, run_now, in_addr;

  assign in_addr   = cur_pos < POS_W'(ADDR_BYTES);
  assign run_now   = (sof ? 1'b1 : run_q) && (!in_addr || (data == 8'hFF));
  assign bcast_now = run_now && (cur_pos >= POS_W'(ADDR_BYTES - 1));
  assign mcast_now = sof ? data[0] : mc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      mc_q  <= 1'b0;
    end else if (beat) begin
      run_q <= run_now;
      mc_q  <= mcast_now;
    end
  end

  // R7: once a non-0xFF address byte is seen, broadcast cannot come back
  p_bcast_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sof && !run_q) |-> !bcast_now)
    else $error("p_bcast_sticky_r7");
endmodule

// File: rtl/wake_pattern_filter.sv
module wake_pattern_filter
  import wpf_pkg::*;
#(
  parameter int MASK_WORDS = 8,
  parameter int WORD_BITS  = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [7:0]                      in_data,
  input  logic                            in_sof,
  input  logic                            in_eof,
  input  logic [15:0]                     cfg_ctrl,
  input  logic [15:0]                     cfg_crc,
  input  logic [MASK_WORDS*WORD_BITS-1:0] cfg_mask,
  output logic                            match_pulse
);
  localparam int WIN_BYTES = MASK_WORDS * WORD_BITS;
  localparam int CNT_W     = $clog2(WIN_BYTES + 1);
  localparam int POS_W     = $clog2((1 << OFS_W) + WIN_BYTES + 1);

  logic [POS_W-1:0] cur_pos;
  logic             in_win, byte_sel, take;
  logic [15:0]      crc_now;
  logic [CNT_W-1:0] taken_now, need_cnt;
  logic             bcast_now, mcast_now;
  logic             frame_end, crc_hit, len_hit, qual_hit, match_d, match_q;
  logic             spare_unused;

  assign spare_unused = ^{cfg_ctrl[14:10], in_win};

  wpf_frame_pos #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .beat(in_valid), .sof(in_sof), .cur_pos(cur_pos));

  wpf_byte_select #(.WIN_BYTES(WIN_BYTES), .POS_W(POS_W), .OFS_W(OFS_W)) u_sel (
    .cur_pos(cur_pos), .ofs(cfg_ctrl[OFS_W-1:0]), .mask(cfg_mask),
    .in_win(in_win), .sel(byte_sel));

  assign take = in_valid && byte_sel;

  wpf_crc_acc #(.WIN_BYTES(WIN_BYTES), .CNT_W(CNT_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .beat(in_valid), .sof(in_sof), .sel(take),
    .data(in_data), .crc_now(crc_now), .taken_now(taken_now));

  wpf_addr_qual #(.POS_W(POS_W), .ADDR_BYTES(ADDR_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .beat(in_valid), .sof(in_sof), .cur_pos(cur_pos),
    .data(in_data), .bcast_now(bcast_now), .mcast_now(mcast_now));

  // number of bytes the mask asks for; fewer taken means the frame was short
  always_comb begin
    need_cnt = '0;
    for (int i = 0; i < WIN_BYTES; i++) need_cnt = need_cnt + CNT_W'(cfg_mask[i]);
  end

  assign frame_end = in_valid && in_eof;
  assign crc_hit   = rev16(crc_now) == cfg_crc;
  assign len_hit   = taken_now == need_cnt;
  assign qual_hit  = (!cfg_ctrl[CTL_MC_BIT] || mcast_now) &&
                     (!cfg_ctrl[CTL_BC_BIT] || bcast_now);
  assign match_d   = frame_end && cfg_ctrl[CTL_EN_BIT] && crc_hit && len_hit && qual_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

  assign match_pulse = match_q;

  // R5: a pulse only follows an accepted end-of-frame byte
  p_pulse_after_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(in_valid && in_eof))
    else $error("p_pulse_after_eof_r5");

  // R2: no pulse unless the filter was enabled
  p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(cfg_ctrl[CTL_EN_BIT]))
    else $error("p_enable_gate_r2");

  // R6: multicast requirement honoured
  p_mcast_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && $past(cfg_ctrl[CTL_MC_BIT])) |-> $past(mcast_now))
    else $error("p_mcast_qual_r6");

  // R7: broadcast requirement honoured
  p_bcast_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && $past(cfg_ctrl[CTL_BC_BIT])) |-> $past(bcast_now))
    else $error("p_bcast_qual_r7");

  // R8: a pulse needs every selected byte to have arrived
  p_full_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(taken_now == need_cnt))
    else $error("p_full_window_r8");
endmodule

// File: tb/wake_pattern_filter_bench.sv
`timescale 1ns/1ps
module wake_pattern_filter_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_sof, in_eof;
  logic [7:0]   in_data;
  logic [15:0]  cfg_ctrl, cfg_crc;
  logic [127:0] cfg_mask;
  logic         match_pulse;

  int    checks = 0;
  int    errors = 0;
  bit    exp_next = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";
  byte unsigned fr[$];

  always #2.5 clk = ~clk;

  wake_pattern_filter u_wake_pattern_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .cfg_ctrl(cfg_ctrl), .cfg_crc(cfg_crc),
    .cfg_mask(cfg_mask), .match_pulse(match_pulse));

  // msb-first crc with 0x8005, message bits taken lsb first per byte;
  // equals the bit-reversed reflected register
  function automatic bit [15:0] fold(input bit [15:0] acc, input byte unsigned b);
    bit fb;
    for (int k = 0; k < 8; k++) begin
      fb  = acc[15] ^ b[k];
      acc = {acc[14:0], 1'b0};
      if (fb) acc = acc ^ 16'h8005;
    end
    return acc;
  endfunction

  function automatic bit [15:0] sel_crc(input byte unsigned f[$], input int ofs,
                                        input logic [127:0] msk);
    bit [15:0] acc = 16'hFFFF;
    for (int w = 0; w < 128; w++)
      if (msk[w] && (ofs + w) < f.size()) acc = fold(acc, f[ofs + w]);
    return acc;
  endfunction

  function automatic bit model_match(input byte unsigned f[$], input logic [15:0] ctl,
                                     input logic [15:0] want, input logic [127:0] msk);
    int ofs = int'(ctl[7:0]);
    if (!ctl[15]) return 1'b0;
    for (int w = 0; w < 128; w++)
      if (msk[w] && (ofs + w) >= f.size()) return 1'b0;
    if (sel_crc(f, ofs, msk) != want) return 1'b0;
    if (ctl[9] && !(f.size() > 0 && f[0][0])) return 1'b0;
    if (ctl[8]) begin
      if (f.size() < 6) return 1'b0;
      for (int i = 0; i < 6; i++) if (f[i] != 8'hFF) return 1'b0;
    end
    return 1'b1;
  endfunction

  // one clock: compare the output, then drive the next input
  task automatic step(input bit v, input logic [7:0] d, input bit s, input bit e);
    @(negedge clk);
    checks++;
    if (match_pulse !== exp_next) begin
      errors++;
      $display("FAIL %s: match_pulse=%0b expected=%0b at %0t", cur_req,
               match_pulse, exp_next, $time);
    end
    exp_next = 1'b0;
    in_valid = v; in_data = d; in_sof = s; in_eof = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  // send fr; every gap-th byte is followed by an invalid junk cycle (R10)
  task automatic send_frame(input int gap);
    bit res;
    res = model_match(fr, cfg_ctrl, cfg_crc, cfg_mask);
    for (int i = 0; i < fr.size(); i++) begin
      step(1'b1, fr[i], i == 0, i == fr.size() - 1);
      if (i == fr.size() - 1) exp_next = res;
      else if (gap > 0 && (i % gap) == gap - 1) step(1'b0, 8'hA5, 1'b1, 1'b1);
    end
  endtask

  task automatic mk_eth(input bit bc, input logic [15:0] etype);
    fr.delete();
    for (int i = 0; i < 6; i++) fr.push_back(bc ? 8'hFF : (i == 0 ? 8'h02 : 8'h00));
    for (int i = 0; i < 6; i++) fr.push_back(8'h10 + i);
    fr.push_back(etype[15:8]);
    fr.push_back(etype[7:0]);
    for (int i = 0; i < 28; i++) fr.push_back(i);
  endtask

  task automatic mk_seq(input int len);
    fr.delete();
    for (int i = 0; i < len; i++) fr.push_back((i * 7 + 3) & 8'hFF);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    byte unsigned pat[$];
    logic [127:0] spread;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
    cfg_ctrl = '0; cfg_crc = '0; cfg_mask = '0;

    // R1: quiet through and after reset
    cur_req = "R1 reset";
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R11: ARP wake, broadcast required, offset 12, mask 0x0003
    cur_req = "R11 arp match";
    pat = '{8'h08, 8'h06};
    cfg_mask = 128'h0003;
    cfg_ctrl = 16'h8000 | 16'h0100 | 16'd12;
    cfg_crc  = sel_crc(pat, 0, 128'h0003);
    mk_eth(1'b1, 16'h0806); send_frame(0); idle(2);
    cur_req = "R11 R7 arp unicast dest";
    mk_eth(1'b0, 16'h0806); send_frame(0); idle(2);
    cur_req = "R4 wrong type bytes";
    mk_eth(1'b1, 16'h0800); send_frame(0); idle(2);
    cur_req = "R7 short broadcast frame";
    fr.delete(); for (int i = 0; i < 5; i++) fr.push_back(8'hFF);
    cfg_ctrl = 16'h8100; cfg_mask = '0; cfg_crc = 16'hFFFF;
    send_frame(0); idle(2);

    // R2: same ARP frame, enable clear
    cur_req = "R2 disabled";
    cfg_mask = 128'h0003; cfg_crc = sel_crc(pat, 0, 128'h0003);
    cfg_ctrl = 16'h0100 | 16'd12;
    mk_eth(1'b1, 16'h0806); send_frame(0); idle(2);

    // R6, R9: empty mask, multicast required
    cur_req = "R6 R9 multicast match";
    cfg_ctrl = 16'h8200; cfg_mask = '0; cfg_crc = 16'hFFFF;
    mk_eth(1'b0, 16'h0800); fr[0] = 8'h01; send_frame(0); idle(2);
    cur_req = "R6 unicast rejected";
    mk_eth(1'b0, 16'h0800); send_frame(0); idle(2);
    cur_req = "R9 R4 empty mask wrong crc";
    cfg_ctrl = 16'h8000; cfg_crc = 16'h1234;
    mk_eth(1'b0, 16'h0800); send_frame(0); idle(2);

    // R3, R8: selected bytes at window ends and middle, offset 3
    spread = '0; spread[0] = 1'b1; spread[5] = 1'b1; spread[50] = 1'b1; spread[127] = 1'b1;
    cfg_mask = spread; cfg_ctrl = 16'h8000 | 16'd3;
    mk_seq(140); cfg_crc = sel_crc(fr, 3, spread);
    cur_req = "R3 spread mask match";      send_frame(0); idle(2);
    cur_req = "R3 selected byte changed";  fr[53] = fr[53] ^ 8'h01; send_frame(0); idle(2);
    cur_req = "R3 unselected byte changed"; fr[53] = fr[53] ^ 8'h01; fr[52] = 8'hEE;
    send_frame(0); idle(2);
    cur_req = "R8 frame ends before last byte"; mk_seq(130); send_frame(0); idle(2);
    cur_req = "R8 frame just long enough";      mk_seq(131); send_frame(0); idle(2);

    // R10: gaps with junk strobes, then back-to-back frames
    cur_req = "R10 gapped frame";       mk_seq(140); send_frame(3); idle(2);
    cur_req = "R10 back to back";       send_frame(0); send_frame(5); idle(2);

    // R5: one-byte frames on consecutive cycles
    cur_req = "R5 single byte frames";
    cfg_ctrl = 16'h8000; cfg_mask = '0; cfg_crc = 16'hFFFF;
    fr.delete(); fr.push_back(8'h42);
    send_frame(0); send_frame(0); send_frame(0); idle(3);

    done = 1'b1;
    finish_run();
  end
endmodule